// File: doc/BRIEF.md
# Addressed Serial Register Bank

This block holds eight 8-bit values that are written through a three-wire serial port: a serial clock, a serial data line and a load strobe. Each frame is twelve bits, sent most significant bit first: a 4-bit channel address and then 8 data bits. Every rising edge of the serial clock moves one bit into a 12-bit shift register. A rising edge of the load strobe copies the low eight bits of that register into the channel that the high four bits select. All eight channel values are presented in parallel.

The bit that leaves the far end of the shift register appears on a serial output. A second bank wired to that output therefore receives the frame sent before the current one, so several banks can share one port. An active-low preset input returns every channel to mid-scale, 0x80. In the offset-binary coding of the data, 0x00 is the most negative level, 0x80 is zero and 0xFF is the most positive level.

The serial inputs and the preset are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected on the synchronized copies. The serial clock therefore has to run well below the system clock.

Top module: `serial_reg_bank`

## Requirements
- R1: After reset, every channel output reads 0x80 and sdo_o reads 0.
- R2: Each rising edge of sclk_i shifts sdi_i into bit 0 of a 12-bit shift register and moves every other bit up one place. A frame is sent in the order address bit 3 down to address bit 0, then data bit 7 down to data bit 0.
- R3: On a rising edge of load_i, the shift register's bits 7:0 are written to the channel whose number is given by bits 11:8, for numbers 0 to 7. Channel k appears on ch_data_o[8k+7:8k].
- R4: A load whose address is in the range 8 to 15 changes no channel.
- R5: sdo_o carries bit 11 of the shift register. After a second frame of 12 bits has been shifted in, the bits of the earlier frame have appeared on sdo_o in the order they were sent.
- R6: While preset_ni is low, every channel is forced to 0x80. Preset takes priority over a load that occurs in the same cycle.
- R7: Only the rising edge of load_i writes a channel. Holding load_i high causes no further writes.
- R8: No channel changes unless there is a load or a preset. In particular, shifting bits into the shift register does not change any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; shifts one bit on each rising edge |
| sdi_i | input | 1 | Serial data in |
| load_i | input | 1 | Load strobe; writes one channel on each rising edge |
| preset_ni | input | 1 | Forces all channels to mid-scale while low |
| sdo_o | output | 1 | Serial data out, for chaining banks |
| ch_data_o | output | 64 | Eight channel values; channel k is at bits 8k+7:8k |

## Verification
The assertions check on every cycle that the shift register shifts by exactly one place on each detected serial edge and holds otherwise. They also check that sdo_o follows the bit that was shifted up, that a preset leaves all channels at 0x80 on the next cycle, and that channels change only on a load with a valid address. The bench's scenarios show the end-to-end behaviour, which no single-cycle property can: that a whole MSB-first frame reaches the intended channel through the synchronizers, that a held strobe writes once, and that a chained bank sees the previous frame on sdo_o.

// File: rtl/srb_pkg.sv
package srb_pkg;
  parameter int unsigned SRB_NUM_CH = 8;
  parameter int unsigned SRB_DATA_W = 8;
  parameter int unsigned SRB_ADDR_W = 4;

  // offset-binary zero: only the top bit set
  function automatic logic [31:0] mid_scale(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/srb_rise_det.sv
module srb_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= 1'b0;
    else         prev <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev;
endmodule

// File: rtl/srb_shifter.sv
module srb_shifter #(
  parameter int unsigned SR_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_en_i,
  input  logic            sdi_i,
  output logic [SR_W-1:0] shreg_o,
  output logic            sdo_o
);
  logic [SR_W-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shreg <= '0;
    else if (shift_en_i) shreg <= {shreg[SR_W-2:0], sdi_i};
  end

  assign shreg_o = shreg;
  assign sdo_o   = shreg[SR_W-1];
endmodule

// File: rtl/srb_bank.sv
module srb_bank #(
  parameter int unsigned          NUM_CH  = 8,
  parameter int unsigned          DATA_W  = 8,
  parameter int unsigned          ADDR_W  = 4,
  parameter logic [DATA_W-1:0]    PRESET  = 8'h80
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     preset_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] ch_data_o
);
  logic [NUM_CH-1:0] we;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [DATA_W-1:0] val;

    // out-of-range addresses match no channel
    assign we[k] = load_i && (int'(addr_i) == k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       val <= PRESET;
      else if (preset_i) val <= PRESET;
      else if (we[k])    val <= data_i;
    end

    assign ch_data_o[k*DATA_W +: DATA_W] = val;
  end
endmodule

// File: rtl/serial_reg_bank.sv
module serial_reg_bank
  import srb_pkg::*;
#(
  parameter int unsigned NUM_CH      = SRB_NUM_CH,
  parameter int unsigned DATA_W      = SRB_DATA_W,
  parameter int unsigned ADDR_W      = SRB_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  input  logic                     load_i,
  input  logic                     preset_ni,
  output logic                     sdo_o,
  output logic [NUM_CH*DATA_W-1:0] ch_data_o
);
  localparam int unsigned       SR_W   = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] PRESET = DATA_W'(mid_scale(DATA_W));

  logic sclk_s, sdi_s, load_s, preset_ns;
  logic shift_en, load_pulse, preset_act;
  logic [SR_W-1:0] shreg;

  srb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  srb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s));
  srb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(load_i), .q_o(load_s));
  srb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_preset (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(preset_ni), .q_o(preset_ns));

  srb_rise_det u_rise_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sclk_s), .rise_o(shift_en));
  srb_rise_det u_rise_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(load_s), .rise_o(load_pulse));

  assign preset_act = ~preset_ns;

  srb_shifter #(.SR_W(SR_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .sdi_i     (sdi_s),
    .shreg_o   (shreg),
    .sdo_o     (sdo_o)
  );

  srb_bank #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESET(PRESET)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_pulse),
    .preset_i (preset_act),
    .addr_i   (shreg[SR_W-1 -: ADDR_W]),
    .data_i   (shreg[DATA_W-1:0]),
    .ch_data_o(ch_data_o)
  );
endmodule

// File: rtl/srb_chk.sv
module srb_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         shift_en_i,
  input logic                         load_pulse_i,
  input logic                         preset_act_i,
  input logic [ADDR_W+DATA_W-1:0]     shreg_i,
  input logic                         sdo_i,
  input logic [NUM_CH*DATA_W-1:0]     ch_data_i
);
  localparam int unsigned       SR_W = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W - 1);

  logic [ADDR_W-1:0] addr;
  logic              addr_ok;
  assign addr    = shreg_i[SR_W-1 -: ADDR_W];
  assign addr_ok = int'(addr) < NUM_CH;

  assert_shift_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> shreg_i[SR_W-1:1] == $past(shreg_i[SR_W-2:0]));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(shreg_i));

  assert_sdo_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> sdo_i == $past(shreg_i[SR_W-2]));

  assert_preset_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_act_i |=> ch_data_i == {NUM_CH{MID}});

  assert_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_pulse_i && !preset_act_i) |=> $stable(ch_data_i));

  assert_bad_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_pulse_i && !preset_act_i && !addr_ok) |=> $stable(ch_data_i));

  assert_load_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_pulse_i && !preset_act_i && addr_ok) |=>
      ch_data_i[int'($past(addr))*DATA_W +: DATA_W] == $past(shreg_i[DATA_W-1:0]));
endmodule

bind serial_reg_bank srb_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_en_i  (shift_en),
  .load_pulse_i(load_pulse),
  .preset_act_i(preset_act),
  .shreg_i     (shreg),
  .sdo_i       (sdo_o),
  .ch_data_i   (ch_data_o)
);

// File: tb/sim_serial_reg_bank.sv
`timescale 1ns/1ps
module sim_serial_reg_bank;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, load = 1'b0, preset_n = 1'b1;
  logic sdo;
  logic [63:0] ch_data;

  int checks = 0, errors = 0;
  logic [7:0]  exp_ch [8];
  logic [11:0] m_sr = '0;

  always #4 clk = ~clk;

  serial_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi),
    .load_i(load), .preset_ni(preset_n), .sdo_o(sdo), .ch_data_o(ch_data)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bank(input string req);
    checks++;
    for (int i = 0; i < 8; i++)
      if (ch_data[i*8 +: 8] !== exp_ch[i]) begin
        errors++;
        $display("FAIL %s ch%0d actual %h expected %h", req, i, ch_data[i*8 +: 8], exp_ch[i]);
        break;
      end
  endtask

  task automatic chk_sdo(input string req);
    checks++;
    if (sdo !== m_sr[11]) begin
      errors++;
      $display("FAIL %s sdo actual %b expected %b", req, sdo, m_sr[11]);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b;
    wait_clk(3); sclk = 1'b1;
    wait_clk(4); sclk = 1'b0;
    wait_clk(3);
    m_sr = {m_sr[10:0], b};
  endtask

  task automatic send_frame(input logic [3:0] a, input logic [7:0] d);
    logic [11:0] f;
    f = {a, d};
    for (int i = 11; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    wait_clk(6); load = 1'b0;
    wait_clk(6);
    if (m_sr[11:8] < 4'd8) exp_ch[m_sr[10:8]] = m_sr[7:0];
  endtask

  function automatic void preset_model();
    for (int i = 0; i < 8; i++) exp_ch[i] = 8'h80;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    void'($urandom(32'd2024));
    preset_model();
    wait_clk(3); rst_ni = 1'b1; wait_clk(3);

    // R1: reset state
    chk_bank("R1");
    chk_sdo("R1");

    // R2 R3: frame to channel 2, MSB first
    send_frame(4'd2, 8'h5A); chk_sdo("R5"); chk_bank("R8 shift only");
    pulse_load(); chk_bank("R3 ch2");
    send_frame(4'd0, 8'h00); pulse_load(); chk_bank("R3 ch0 low");
    send_frame(4'd7, 8'hFF); pulse_load(); chk_bank("R3 ch7 high");
    send_frame(4'd5, 8'h81); pulse_load(); chk_bank("R2 order");

    // R4: out-of-range addresses
    send_frame(4'd9, 8'h33);  pulse_load(); chk_bank("R4 addr9");
    send_frame(4'd15, 8'hC3); pulse_load(); chk_bank("R4 addr15");
    send_frame(4'd8, 8'h11);  pulse_load(); chk_bank("R4 addr8");

    // R5: daisy chain, earlier frame leaves on sdo
    send_frame(4'd3, 8'hA5);
    prev = m_sr;
    begin
      logic [11:0] nf;
      nf = {4'd6, 8'h3C};
      for (int i = 11; i >= 0; i--) begin
        checks++;
        if (sdo !== prev[i]) begin
          errors++;
          $display("FAIL R5 chain bit %0d actual %b expected %b", i, sdo, prev[i]);
        end
        send_bit(nf[i]);
      end
    end
    pulse_load(); chk_bank("R5 second frame");

    // R6: preset
    @(negedge clk); preset_n = 1'b0; wait_clk(6);
    preset_model(); chk_bank("R6 preset");
    @(negedge clk); preset_n = 1'b1; wait_clk(6); chk_bank("R6 release");

    // R6: preset and load together, preset wins
    send_frame(4'd1, 8'h77);
    @(negedge clk); preset_n = 1'b0; load = 1'b1;
    wait_clk(6); preset_n = 1'b1; wait_clk(6); load = 1'b0; wait_clk(6);
    chk_bank("R6 priority");

    // R7: held strobe writes once
    send_frame(4'd4, 8'h2E);
    @(negedge clk); load = 1'b1; wait_clk(6);
    exp_ch[4] = 8'h2E; chk_bank("R7 first write");
    preset_n = 1'b0; wait_clk(6); preset_n = 1'b1; wait_clk(8);
    preset_model(); chk_bank("R7 held no rewrite");
    load = 1'b0; wait_clk(6);

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      send_frame(a, d);
      chk_sdo("R5 random");
      if ($urandom_range(0, 3) != 0) begin
        pulse_load();
        chk_bank(a < 4'd8 ? "R3 random" : "R4 random");
      end else begin
        chk_bank("R8 random");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule